// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is a free-running time base for the always-on domain. It runs directly on the 32.768 kHz clock and holds one count register. The upper word is whole seconds and the low `FRAC_W` bits are the sub-second fraction; with the default of 15 bits, one second is exactly 32768 clocks. A single seconds-only alarm comparator sets a sticky flag when the time reaches the programmed second. That flag drives a level interrupt through an enable bit.

Software reaches the block through one-cycle write strobes that share a data bus. The bus-side synchronisation is assumed to be done elsewhere. An external security monitor can freeze the count so that the moment of an event is kept. Lock bits in the control word protect the time registers.

Counting happens only when all of these hold:
- the enable bit is set;
- the overflow flag is clear;
- the not-valid flag is clear;
- a time has been loaded since reset;
- the freeze input is low.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the seconds and fraction read 0, the alarm reads all ones, the control word reads 0, the not-valid flag (status bit 2) is 1, the overflow flag (status bit 0) and alarm flag (status bit 1) are 0, and `irq` is 0.
- R2: While counting, the combined {seconds, fraction} value rises by exactly 1 per clock. The fraction carries into the seconds after 2^FRAC_W clocks.
- R3: With the enable bit (control bit 0) clear, the count holds its value.
- R4: While the not-valid flag is set, the count holds. After the flag is cleared by writing 1 to status bit 2, the count still holds until the seconds word has been written.
- R5: While `secFail` is high, the count holds. It resumes on the first clock after `secFail` falls.
- R6: When the count advances from all ones, it wraps to zero and sets the overflow flag. It then holds until software writes 1 to status bit 0.
- R7: The alarm flag sets on the clock edge where the fraction rolls over and the new seconds value equals the alarm word. Writing 1 to status bit 1 clears it.
- R8: `irq` is high exactly while both the alarm flag and the alarm interrupt enable (control bit 3) are set.
- R9: Once the soft lock (control bit 1) or the hard lock (control bit 2) is set, writes to the seconds, the fraction and the enable bit are ignored. The lock bits stay set until reset.
- R10: A seconds write loads on the next clock edge and leaves the fraction unchanged. A fraction write leaves the seconds unchanged. The count does not advance in a cycle that performs a time write.
- R11: A status write clears only the flags whose bits are 1. Writing 0 to a flag bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrSec | input | 1 | Write strobe for the seconds word |
| wrFrac | input | 1 | Write strobe for the fraction |
| wrAlarm | input | 1 | Write strobe for the alarm seconds |
| wrCtrl | input | 1 | Write strobe for the control word |
| wrStat | input | 1 | Write-1-to-clear strobe for the status flags |
| wrData | input | SEC_W | Write data shared by all strobes |
| secFail | input | 1 | Freeze request from the security monitor |
| secOut | output | SEC_W | Current seconds |
| fracOut | output | FRAC_W | Current fraction |
| alarmOut | output | SEC_W | Alarm seconds |
| ctrlOut | output | 4 | {alarm irq enable, hard lock, soft lock, enable} |
| statOut | output | 3 | {not-valid, alarm flag, overflow flag} |
| running | output | 1 | Count advances on the next edge |
| irq | output | 1 | Level alarm interrupt |

## Verification
A wrong stop condition or carry in the count shows up on `secOut`/`fracOut` one clock later, as a value that is off by one or frozen. Comparing each cycle against an arithmetic total exposes it immediately. A mis-timed alarm match shows up on the status output on the exact rollover edge, either one second early or late. A lock that is not enforced shows up as a changed time value on the cycle after the ignored write.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  // Per-cycle commands from control to the count register
  typedef struct packed {
    logic loadSec;
    logic loadFrac;
    logic advance;
  } cntStrobe_t;
endpackage

// File: rtl/rtc_sec_datapath.sv
module rtc_sec_datapath
  import rtc_sec_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        stb,
  input  logic              wrAlarm,
  input  logic [SEC_W-1:0]  wrData,
  output logic [SEC_W-1:0]  secQ,
  output logic [FRAC_W-1:0] fracQ,
  output logic [SEC_W-1:0]  alarmQ,
  output logic              carryOut,
  output logic              alarmHit
);
  localparam int CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;

  assign cntNext = cntQ + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      if (stb.loadSec)  cntQ[CNT_W-1:FRAC_W] <= wrData;
      if (stb.loadFrac) cntQ[FRAC_W-1:0]     <= wrData[FRAC_W-1:0];
      if (stb.advance)  cntQ                 <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        alarmQ <= '1;
    else if (wrAlarm) alarmQ <= wrData;
  end

  // carry out of the full count, and seconds match at fraction rollover
  assign carryOut = stb.advance && (&cntQ);
  assign alarmHit = stb.advance && (&cntQ[FRAC_W-1:0]) &&
                    (cntNext[CNT_W-1:FRAC_W] == alarmQ);

  assign secQ  = cntQ[CNT_W-1:FRAC_W];
  assign fracQ = cntQ[FRAC_W-1:0];
endmodule

// File: rtl/rtc_sec_control.sv
module rtc_sec_control
  import rtc_sec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrSec,
  input  logic       wrFrac,
  input  logic       wrCtrl,
  input  logic       wrStat,
  input  logic [3:0] ctlData,
  input  logic       secFail,
  input  logic       carryOut,
  input  logic       alarmHit,
  output cntStrobe_t stb,
  output logic [3:0] ctrlQ,
  output logic [2:0] statQ,
  output logic       running,
  output logic       irq
);
  logic enQ, softLockQ, hardLockQ, irqEnQ;
  logic ovfQ, almQ, nvQ, needTimeQ;
  logic locked;

  assign locked = softLockQ | hardLockQ;

  always_comb begin
    stb.loadSec  = wrSec  && !locked;
    stb.loadFrac = wrFrac && !locked;
    running      = enQ && !ovfQ && !nvQ && !needTimeQ && !secFail;
    stb.advance  = running && !stb.loadSec && !stb.loadFrac;
  end

  // control word: lock bits are sticky, enable obeys the locks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      softLockQ <= 1'b0;
      hardLockQ <= 1'b0;
      irqEnQ    <= 1'b0;
    end else if (wrCtrl) begin
      if (!locked) enQ <= ctlData[0];
      softLockQ <= softLockQ | ctlData[1];
      hardLockQ <= hardLockQ | ctlData[2];
      irqEnQ    <= ctlData[3];
    end
  end

  // status flags: hardware set has priority over write-1 clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ      <= 1'b0;
      almQ      <= 1'b0;
      nvQ       <= 1'b1;
      needTimeQ <= 1'b1;
    end else begin
      if (carryOut)                   ovfQ <= 1'b1;
      else if (wrStat && ctlData[0])  ovfQ <= 1'b0;
      if (alarmHit)                   almQ <= 1'b1;
      else if (wrStat && ctlData[1])  almQ <= 1'b0;
      if (wrStat && ctlData[2])       nvQ  <= 1'b0;
      if (stb.loadSec)                needTimeQ <= 1'b0;
    end
  end

  assign ctrlQ = {irqEnQ, hardLockQ, softLockQ, enQ};
  assign statQ = {nvQ, almQ, ovfQ};
  assign irq   = almQ & irqEnQ;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_sec_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrSec,
  input  logic              wrFrac,
  input  logic              wrAlarm,
  input  logic              wrCtrl,
  input  logic              wrStat,
  input  logic [SEC_W-1:0]  wrData,
  input  logic              secFail,
  output logic [SEC_W-1:0]  secOut,
  output logic [FRAC_W-1:0] fracOut,
  output logic [SEC_W-1:0]  alarmOut,
  output logic [3:0]        ctrlOut,
  output logic [2:0]        statOut,
  output logic              running,
  output logic              irq
);
  cntStrobe_t stb;
  logic carryOut, alarmHit;

  rtc_sec_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrSec(wrSec), .wrFrac(wrFrac),
    .wrCtrl(wrCtrl), .wrStat(wrStat), .ctlData(wrData[3:0]),
    .secFail(secFail), .carryOut(carryOut), .alarmHit(alarmHit),
    .stb(stb), .ctrlQ(ctrlOut), .statQ(statOut), .running(running), .irq(irq)
  );

  rtc_sec_datapath #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAlarm(wrAlarm), .wrData(wrData),
    .secQ(secOut), .fracQ(fracOut), .alarmQ(alarmOut),
    .carryOut(carryOut), .alarmHit(alarmHit)
  );
endmodule

// File: rtl/rtc_sec_checker.sv
module rtc_sec_checker #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrSec,
  input logic              wrFrac,
  input logic              wrAlarm,
  input logic              secFail,
  input logic [SEC_W-1:0]  secOut,
  input logic [FRAC_W-1:0] fracOut,
  input logic [SEC_W-1:0]  alarmOut,
  input logic [3:0]        ctrlOut,
  input logic [2:0]        statOut,
  input logic              irq
);
  logic noTimeWr;
  assign noTimeWr = !wrSec && !wrFrac;

  p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlOut[0] && noTimeWr) |=> ($stable(secOut) && $stable(fracOut)));

  p_hold_notvalid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statOut[2] && noTimeWr) |=> ($stable(secOut) && $stable(fracOut)));

  p_freeze_fail_r5: assert property (@(posedge clk) disable iff (!rstN)
    (secFail && noTimeWr) |=> ($stable(secOut) && $stable(fracOut)));

  p_ovf_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statOut[0] && noTimeWr) |=> $stable(fracOut));

  p_ovf_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statOut[0]) && $past(noTimeWr)) |-> (secOut == '0 && fracOut == '0));

  p_alarm_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statOut[1]) && $past(noTimeWr) && $past(!wrAlarm))
      |-> (fracOut == '0 && secOut == alarmOut));

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statOut[1] && ctrlOut[3]));

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlOut[1]) |-> ctrlOut[1]) and ($past(ctrlOut[2]) |-> ctrlOut[2]));
endmodule

bind rtc_sec_alarm rtc_sec_checker #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrSec(wrSec), .wrFrac(wrFrac), .wrAlarm(wrAlarm),
  .secFail(secFail), .secOut(secOut), .fracOut(fracOut), .alarmOut(alarmOut),
  .ctrlOut(ctrlOut), .statOut(statOut), .irq(irq)
);

// File: tb/rtc_sec_alarm_bench.sv
module rtc_sec_alarm_bench;
  localparam int SW = 32;
  localparam int FW = 3;
  localparam int K_SEC = 0, K_FRAC = 1, K_ALARM = 2, K_CTRL = 3, K_STAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrSec = 1'b0, wrFrac = 1'b0, wrAlarm = 1'b0, wrCtrl = 1'b0, wrStat = 1'b0;
  logic [SW-1:0] wrData = '0;
  logic secFail = 1'b0;
  logic [SW-1:0] secOut, alarmOut;
  logic [FW-1:0] fracOut;
  logic [3:0] ctrlOut;
  logic [2:0] statOut;
  logic running, irq;

  int nChk = 0;
  int nBad = 0;
  longint unsigned expTot;

  always #5 clk = ~clk;

  rtc_sec_alarm #(.SEC_W(SW), .FRAC_W(FW)) u_rtc_sec_alarm (
    .clk(clk), .rstN(rstN), .wrSec(wrSec), .wrFrac(wrFrac), .wrAlarm(wrAlarm),
    .wrCtrl(wrCtrl), .wrStat(wrStat), .wrData(wrData), .secFail(secFail),
    .secOut(secOut), .fracOut(fracOut), .alarmOut(alarmOut), .ctrlOut(ctrlOut),
    .statOut(statOut), .running(running), .irq(irq)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkTime(input string req);
    chk(req, {secOut, fracOut}, expTot);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int kind, input logic [SW-1:0] d);
    wrData = d;
    case (kind)
      K_SEC:   wrSec = 1'b1;
      K_FRAC:  wrFrac = 1'b1;
      K_ALARM: wrAlarm = 1'b1;
      K_CTRL:  wrCtrl = 1'b1;
      default: wrStat = 1'b1;
    endcase
    @(negedge clk);
    {wrSec, wrFrac, wrAlarm, wrCtrl, wrStat} = '0;
    wrData = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 sec", secOut, 0);
    chk("R1 frac", fracOut, 0);
    chk("R1 alarm", alarmOut, 64'hFFFF_FFFF);
    chk("R1 ctrl", ctrlOut, 0);
    chk("R1 stat", statOut, 3'b100);
    chk("R1 irq", irq, 0);

    // R4 not-valid and missing time both hold the count
    expTot = 0;
    wr(K_CTRL, 1);
    tick(5);
    chkTime("R4 hold while not-valid");
    wr(K_STAT, 4);
    tick(3);
    chk("R4 not-valid cleared", statOut[2], 0);
    chkTime("R4 hold until time written");
    wr(K_SEC, 5);
    expTot = 5 << FW;
    chkTime("R10 seconds load");

    // R2 sweep across several fraction rollovers
    for (int n = 1; n <= 20; n++) begin
      tick(1);
      expTot++;
      chkTime("R2 count step");
    end

    // R10 separate loads keep the other field
    wr(K_FRAC, 6);
    expTot = (expTot & ~64'(7)) | 6;
    chkTime("R10 fraction load keeps seconds");
    wr(K_SEC, 100);
    expTot = (64'(100) << FW) | (expTot & 7);
    chkTime("R10 seconds load keeps fraction");

    // R3 disable holds
    wr(K_CTRL, 0);
    expTot++;
    tick(10);
    chkTime("R3 disabled hold");
    wr(K_CTRL, 1);
    chkTime("R3 enable takes effect after write");

    // R5 freeze from security monitor
    secFail = 1'b1;
    tick(10);
    chkTime("R5 frozen");
    secFail = 1'b0;
    tick(3);
    expTot += 3;
    chkTime("R5 resumes");

    // R7 alarm two seconds ahead
    begin
      longint unsigned a;
      longint unsigned k;
      a = (expTot >> FW) + 2;
      wr(K_ALARM, SW'(a));
      expTot++;
      k = (a << FW) - expTot;
      tick(int'(k) - 1);
      expTot += k - 1;
      chk("R7 flag not yet set", statOut[1], 0);
      tick(1);
      expTot++;
      chk("R7 flag set at rollover", statOut[1], 1);
      chkTime("R7 time at match");
      chk("R8 irq masked", irq, 0);
    end
    wr(K_CTRL, 9);
    expTot++;
    chk("R8 irq when enabled", irq, 1);
    wr(K_STAT, 0);
    expTot++;
    chk("R11 write zero keeps flag", statOut[1], 1);
    wr(K_STAT, 2);
    expTot++;
    chk("R7 flag cleared", statOut[1], 0);
    chk("R8 irq drops", irq, 0);
    chkTime("R2 counting through status writes");

    // R6 overflow
    wr(K_SEC, 32'hFFFF_FFFF);
    wr(K_FRAC, 7);
    tick(1);
    expTot = 0;
    chkTime("R6 wrap to zero");
    chk("R6 overflow flag", statOut[0], 1);
    tick(5);
    chkTime("R6 halted");
    wr(K_STAT, 1);
    chk("R6 overflow cleared", statOut[0], 0);
    tick(3);
    expTot = 3;
    chkTime("R6 resumes");

    // R9 soft lock
    wr(K_CTRL, 3);
    expTot++;
    wr(K_SEC, 50);
    expTot++;
    chkTime("R9 seconds write ignored");
    wr(K_CTRL, 2);
    expTot++;
    chk("R9 enable kept", ctrlOut[0], 1);
    wr(K_CTRL, 0);
    expTot++;
    chk("R9 soft lock sticky", ctrlOut[1], 1);
    chkTime("R9 still counting");

    // R9 hard lock after a fresh reset
    doReset();
    wr(K_CTRL, 4);
    wr(K_FRAC, 5);
    chk("R9 fraction write ignored", fracOut, 0);
    chk("R9 hard lock set", ctrlOut[2], 1);
    wr(K_CTRL, 1);
    chk("R9 enable write ignored", ctrlOut[0], 0);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule